// File: doc/BRIEF.md
# Luma Gain, Sync and Blanking Inserter

This block conditions the luminance sample stream on its way to a 10-bit video DAC. Each incoming 8-bit luma sample is scaled by a programmable fixed-point gain, lifted by a programmable black-level offset, and clipped to the 10-bit code range. The result is the active video code.

Two timing flags come in with each sample. While the sync flag is high, the output is driven to a fixed sync code. While only the blank flag is high, the output is driven to a programmable blanking code. The change between the active code and one of these forced levels is not a step. The output is a linear blend that moves one quarter of the way per sample, so sync and blanking edges are slower than the luma bandwidth.

The gain, black-level and blanking settings are presented on ports. The block captures them only on samples marked as the first of a line, so a change never lands in the middle of a line. The output is registered and lags its input sample by one clock.

Top module: `luma_level_inserter`

## Requirements
- R1: While rst_n is low, code_o is 0. Reset loads the captured settings with gain 128 (unity), black level 64 and blanking level 64, so a first line without a line-start sample uses those values.
- R2: The active code is floor(luma_i × gain / 128) + black. gain is a 9-bit unsigned value with 7 fractional bits. code_o presents the result of a sample on the clock edge that samples it, and it remains valid until the next edge.
- R3: When the active sum exceeds 1023, the active code is clipped to 1023.
- R4: The sync level is the fixed code SYNC_CODE (default 16). After 4 consecutive samples with sync_i high, code_o equals SYNC_CODE.
- R5: After 4 consecutive samples with blank_i high and sync_i low, code_o equals the captured blanking level.
- R6: A blend weight w in 0..4 starts at 0 after reset. It rises by 1 on each sample with sync_i or blank_i high and falls by 1 on each sample with both low, limited to the range 0..4. The output is floor((active × (4 − w) + level × w) / 4). On a forced sample, the level is the sync or blanking level chosen by that sample. On a sample with both flags low, the level is the one last forced. Between two consecutive samples, w changes by at most 1.
- R7: When sync_i and blank_i are both high, the sync level is used.
- R8: gain_i, black_i and blank_lvl_i are captured only on samples with line_start_i high, and they take effect from that sample on. On any other sample, changes on these ports have no effect on code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| luma_i | input | 8 | Luminance sample |
| sync_i | input | 1 | Sample lies inside a sync pulse |
| blank_i | input | 1 | Sample lies inside the blanking interval |
| line_start_i | input | 1 | First sample of a line; settings are captured on this sample |
| gain_i | input | 9 | Gain, unsigned with 7 fractional bits |
| black_i | input | 10 | Black-level offset added after the gain |
| blank_lvl_i | input | 10 | Blanking level code |
| code_o | output | 10 | Registered DAC code |

## Verification
The bound checker runs on every cycle. It checks that a sync run of four samples settles exactly on the sync code and that a run of four blank-only samples settles on the captured blanking level. It also checks that the blend weight never moves by more than one step per sample and that the captured gain holds still on every sample that is not a line start. The arithmetic can only be shown by the bench's scenarios, which compare every output sample against a model built from the requirements. These scenarios cover the gain and offset results, saturation, the exact intermediate codes of each ramp, sync priority, the level switch inside a forced interval, and settings that are ignored in mid-line.

// File: rtl/lli_pkg.sv
package lli_pkg;
    parameter int LUMA_W    = 8;
    parameter int OUT_W     = 10;
    parameter int GAIN_W    = 9;
    parameter int GAIN_FRAC = 7;
    parameter int RAMP_LOG2 = 2;

    localparam int RAMP_LEN = 1 << RAMP_LOG2;
    localparam int WGT_W    = RAMP_LOG2 + 1;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [OUT_W-1:0]  black;
        logic [OUT_W-1:0]  blank;
    } settings_t;
endpackage

// File: rtl/lli_gain_offset.sv
module lli_gain_offset
    import lli_pkg::*;
(
    input  logic [LUMA_W-1:0] luma,
    input  logic [GAIN_W-1:0] gain,
    input  logic [OUT_W-1:0]  black,
    output logic [OUT_W-1:0]  active
);
    localparam int PROD_W = LUMA_W + GAIN_W;
    localparam logic [PROD_W:0] MAXV = (PROD_W+1)'((1 << OUT_W) - 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W:0]   sum;

    always_comb begin
        prod   = PROD_W'(luma) * PROD_W'(gain);
        sum    = (PROD_W+1)'(prod >> GAIN_FRAC) + (PROD_W+1)'(black);
        active = (sum > MAXV) ? '1 : sum[OUT_W-1:0];
    end
endmodule

// File: rtl/lli_ramp_mix.sv
module lli_ramp_mix
    import lli_pkg::*;
(
    input  logic [OUT_W-1:0] active,
    input  logic [OUT_W-1:0] level,
    input  logic [WGT_W-1:0] wgt,
    output logic [OUT_W-1:0] mixed
);
    localparam int MIX_W = OUT_W + WGT_W + 1;

    logic [MIX_W-1:0] acc;

    always_comb begin
        acc   = MIX_W'(active) * MIX_W'(RAMP_LEN - int'(wgt))
              + MIX_W'(level)  * MIX_W'(wgt);
        mixed = acc[RAMP_LOG2 +: OUT_W];
    end
endmodule

// File: rtl/luma_level_inserter.sv
module luma_level_inserter
    import lli_pkg::*;
#(
    parameter logic [OUT_W-1:0]  SYNC_CODE = 16,
    parameter logic [GAIN_W-1:0] GAIN_RST  = 128,
    parameter logic [OUT_W-1:0]  BLACK_RST = 64,
    parameter logic [OUT_W-1:0]  BLANK_RST = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUMA_W-1:0] luma_i,
    input  logic              sync_i,
    input  logic              blank_i,
    input  logic              line_start_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [OUT_W-1:0]  black_i,
    input  logic [OUT_W-1:0]  blank_lvl_i,
    output logic [OUT_W-1:0]  code_o
);
    localparam logic [WGT_W-1:0] WGT_MAX = WGT_W'(RAMP_LEN);

    typedef struct packed {
        settings_t        cfg;
        logic [WGT_W-1:0] wgt;
        logic [OUT_W-1:0] lvl;
        logic [OUT_W-1:0] code;
    } state_t;

    state_t q, d;

    settings_t        cfg_eff;
    logic [WGT_W-1:0] wgt_nx;
    logic [OUT_W-1:0] lvl_nx;
    logic [OUT_W-1:0] active;
    logic [OUT_W-1:0] mixed;
    logic             forced;

    // signals observed by the bound checker
    logic [WGT_W-1:0]  wgt_mon;
    logic [GAIN_W-1:0] gain_mon;
    logic [OUT_W-1:0]  blank_eff;

    // settings for this sample: new values on a line start, held ones otherwise
    always_comb begin
        if (line_start_i) begin
            cfg_eff.gain  = gain_i;
            cfg_eff.black = black_i;
            cfg_eff.blank = blank_lvl_i;
        end else begin
            cfg_eff = q.cfg;
        end
    end

    // blend weight and forced level for this sample
    always_comb begin
        forced = sync_i | blank_i;
        wgt_nx = q.wgt;
        lvl_nx = q.lvl;
        if (forced) begin
            if (q.wgt != WGT_MAX) wgt_nx = q.wgt + 1'b1;
            lvl_nx = sync_i ? SYNC_CODE : cfg_eff.blank;
        end else if (q.wgt != '0) begin
            wgt_nx = q.wgt - 1'b1;
        end
    end

    lli_gain_offset u_gain (
        .luma   (luma_i),
        .gain   (cfg_eff.gain),
        .black  (cfg_eff.black),
        .active (active)
    );

    lli_ramp_mix u_mix (
        .active (active),
        .level  (lvl_nx),
        .wgt    (wgt_nx),
        .mixed  (mixed)
    );

    always_comb begin
        d      = q;
        d.cfg  = cfg_eff;
        d.wgt  = wgt_nx;
        d.lvl  = lvl_nx;
        d.code = mixed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg.gain  <= GAIN_RST;
            q.cfg.black <= BLACK_RST;
            q.cfg.blank <= BLANK_RST;
            q.wgt       <= '0;
            q.lvl       <= SYNC_CODE;
            q.code      <= '0;
        end else begin
            q <= d;
        end
    end

    assign code_o    = q.code;
    assign wgt_mon   = q.wgt;
    assign gain_mon  = q.cfg.gain;
    assign blank_eff = cfg_eff.blank;
endmodule

// File: rtl/lli_checker.sv
module lli_checker
    import lli_pkg::*;
#(
    parameter logic [OUT_W-1:0] SYNC_CODE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic              blank_i,
    input logic              line_start_i,
    input logic [OUT_W-1:0]  code_o,
    input logic [WGT_W-1:0]  wgt_mon,
    input logic [GAIN_W-1:0] gain_mon,
    input logic [OUT_W-1:0]  blank_eff
);
    int sync_run_q;
    int blank_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_run_q  <= 0;
            blank_run_q <= 0;
        end else begin
            sync_run_q  <= sync_i ? ((sync_run_q < RAMP_LEN) ? sync_run_q + 1 : sync_run_q) : 0;
            blank_run_q <= (blank_i && !sync_i)
                         ? ((blank_run_q < RAMP_LEN) ? blank_run_q + 1 : blank_run_q) : 0;
        end
    end

    // R4: a full sync run settles on the fixed sync code
    a_r4_sync_settles: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && sync_run_q >= RAMP_LEN - 1) |=> (code_o == SYNC_CODE));

    // R5: a full blank-only run settles on the captured blanking level
    a_r5_blank_settles: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_i && !sync_i && blank_run_q >= RAMP_LEN - 1) |=> (code_o == $past(blank_eff)));

    // R6: the blend weight moves by at most one step per sample
    a_r6_weight_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int'(wgt_mon) - int'($past(wgt_mon)) <= 1) &&
                  (int'($past(wgt_mon)) - int'(wgt_mon) <= 1)));

    // R8: captured gain holds on samples that are not line starts
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> $stable(gain_mon));
endmodule

bind luma_level_inserter lli_checker #(.SYNC_CODE(SYNC_CODE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .blank_i      (blank_i),
    .line_start_i (line_start_i),
    .code_o       (code_o),
    .wgt_mon      (wgt_mon),
    .gain_mon     (gain_mon),
    .blank_eff    (blank_eff)
);

// File: tb/luma_level_inserter_bench.sv
module luma_level_inserter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] luma_i = '0;
    logic       sync_i = 1'b0;
    logic       blank_i = 1'b0;
    logic       line_start_i = 1'b0;
    logic [8:0] gain_i = '0;
    logic [9:0] black_i = '0;
    logic [9:0] blank_lvl_i = '0;
    logic [9:0] code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // requirement model state
    int m_gain = 128, m_black = 64, m_blank = 64;
    int m_w = 0, m_lvl = 16;

    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    luma_level_inserter u_luma_level_inserter (
        .clk(clk), .rst_n(rst_n), .luma_i(luma_i), .sync_i(sync_i),
        .blank_i(blank_i), .line_start_i(line_start_i), .gain_i(gain_i),
        .black_i(black_i), .blank_lvl_i(blank_lvl_i), .code_o(code_o)
    );

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: code_o=%0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic drive(input int luma, input bit s, input bit b, input bit ls,
                         input int g, input int blk, input int bl, input string tag);
        int act_v;
        @(negedge clk);
        luma_i = 8'(luma); sync_i = s; blank_i = b; line_start_i = ls;
        gain_i = 9'(g); black_i = 10'(blk); blank_lvl_i = 10'(bl);
        if (ls) begin m_gain = g; m_black = blk; m_blank = bl; end
        act_v = (luma * m_gain) / 128 + m_black;
        if (act_v > 1023) act_v = 1023;
        if (s || b) begin
            if (m_w < 4) m_w++;
            m_lvl = s ? 16 : m_blank;
        end else if (m_w > 0) m_w--;
        exp_q.push_back((act_v * (4 - m_w) + m_lvl * m_w) / 4);
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expected item per registered sample
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), int'(code_o), exp_q.pop_front());
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: code_o=%0d expected completion", code_o);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", int'(code_o), 0);
        rst_n = 1'b1;

        // R1/R8: reset defaults in force, port values ignored without line start
        drive(100, 0, 0, 0, 300, 500, 900, "R1 default settings");
        drive(50,  0, 0, 0, 300, 500, 900, "R8 mid-line change ignored");

        // R2: gain and offset
        drive(0,   0, 0, 1, 128, 64, 64, "R2 unity black");
        drive(255, 0, 0, 0, 128, 64, 64, "R2 unity peak");
        drive(200, 0, 0, 1, 256, 0, 64,  "R2 gain two");
        drive(100, 0, 0, 1, 96,  0, 64,  "R2 gain three quarters");
        drive(255, 0, 0, 1, 511, 0, 64,  "R2 max gain no clip");

        // R3: saturation
        drive(255, 0, 0, 1, 511, 10, 64,   "R3 clip small offset");
        drive(255, 0, 0, 1, 511, 1023, 64, "R3 clip full offset");

        // R4/R6: sync ramp in and out
        drive(180, 0, 0, 1, 128, 64, 200, "R6 active before sync");
        for (int i = 0; i < 6; i++) drive(180, 1, 0, 0, 128, 64, 200, "R4 sync ramp");
        for (int i = 0; i < 5; i++) drive(180, 0, 0, 0, 128, 64, 200, "R6 sync release ramp");

        // R5/R6: blanking ramp
        for (int i = 0; i < 6; i++) drive(120, 0, 1, 0, 128, 64, 200, "R5 blank ramp");
        for (int i = 0; i < 5; i++) drive(120, 0, 0, 0, 128, 64, 200, "R6 blank release ramp");

        // R7: sync wins over blank
        for (int i = 0; i < 6; i++) drive(120, 1, 1, 0, 128, 64, 200, "R7 sync priority");
        for (int i = 0; i < 4; i++) drive(120, 0, 0, 0, 128, 64, 200, "R6 release after both");

        // R6: level switch inside a forced interval
        for (int i = 0; i < 3; i++) drive(90, 0, 1, 0, 128, 64, 200, "R6 blank then sync");
        for (int i = 0; i < 3; i++) drive(90, 1, 0, 0, 128, 64, 200, "R6 sync after blank");
        for (int i = 0; i < 4; i++) drive(90, 0, 0, 0, 128, 64, 200, "R6 release from sync");

        // R8: blanking level change mid-line ignored, then taken on line start
        for (int i = 0; i < 5; i++) drive(90, 0, 1, 0, 128, 64, 100, "R8 blank level held");
        drive(90, 0, 1, 1, 128, 64, 100, "R8 blank level captured");
        for (int i = 0; i < 4; i++) drive(90, 0, 1, 0, 128, 64, 100, "R5 new blank level");
        for (int i = 0; i < 4; i++) drive(90, 0, 0, 0, 200, 0, 100, "R8 gain change ignored");
        drive(90, 0, 0, 1, 200, 0, 100, "R8 gain captured");

        @(negedge clk);
        sync_i = 1'b0; blank_i = 1'b0; line_start_i = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule